// File: doc/BRIEF.md
# Striped rotate-exchange bit permuter

This block rearranges the bits of a 32-bit operand under the control of two 5-bit amounts, a primary amount and an alternate amount, plus a stripe flag. The operand is copied into both halves of a 64-bit working word. The word then passes through five conditional-move layers, with move distances of 16, 8, 4, 2 and 1. In each layer, each bit position takes its control from either the primary or the alternate amount, depending on one bit of its own index. When the tested control bit is 1, the position takes the bit that lies the layer's distance above it.

When both amounts are equal and striping is off, the result is a plain right rotation. Unequal amounts give position-dependent rotations. Striping inverts the control in the first layer for every position whose index bit 2 is clear. The unit is used as the datapath of a rotate-and-exchange instruction.

A parameter selects whether the result is combinational or held in a single output register. In the registered form a valid strobe follows the input strobe by one cycle.

Top module: `bit_stripe_permuter`

## Requirements
- R1: While `rst_n` is low (registered form), `out_valid` is 0 and `result` is 0.
- R2: In the registered form, `out_valid` is high exactly in the cycle after a cycle in which `in_valid` was high, and `result` then holds the permutation of the operand presented in that earlier cycle.
- R3: With `amt_a == amt_b` and `stripe_en` = 0, `result[i]` equals `operand[(i + amt_a) mod 32]`, which is a right rotation by `amt_a`. Zero amounts give the operand unchanged.
- R4: With both amounts 0 and `stripe_en` = 1, every result bit whose index has bit 2 clear comes from `operand[(i + 16) mod 32]`. Every other result bit equals `operand[i]`. Equivalently, the result is `(rotr16(x) & 32'h0F0F0F0F) | (x & 32'hF0F0F0F0)`.
- R5: The result matches the five-layer definition for all control values. The working word is `{x, x}`. Layer k, for k = 0..4, has distance d = 16 >> k and covers positions 0 to 30 + d. Position i in a layer uses `amt_a` when bit log2(d)-1 of i is 1, and `amt_b` when that bit is 0. The last layer (d = 1) always uses `amt_a`. In layer 0 only, the control is inverted when `stripe_en` is 1 and bit 2 of i is 0. If bit log2(d) of the control is 1, the position takes bit i+d of the previous layer's word; otherwise it keeps its own bit. The result is bits 31:0 of the last layer's word.
- R6: In the registered form, `result` does not change in a cycle that follows a cycle with `in_valid` low.
- R7: Bit 0 of `amt_b` has no effect on `result`, because the distance-1 layer reads only `amt_a`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand and controls are valid this cycle |
| operand | input | 32 | Value to permute |
| amt_a | input | 5 | Primary control amount |
| amt_b | input | 5 | Alternate control amount |
| stripe_en | input | 1 | Inverts layer-0 control on positions with index bit 2 clear |
| out_valid | output | 1 | Result is valid |
| result | output | 32 | Permuted value |

## Verification
Equal amounts without striping are tried at every rotate distance. This separates a correct chain of distances from a swapped or missing layer, because each distance gives a distinct rotation. Zero amounts with striping on isolate the layer-0 inversion mask. An exhaustive sweep of both amounts and both stripe settings over two operands with asymmetric bit patterns exposes any wrong selector index or wrong tested control bit. Toggling the alternate amount's lowest bit, and holding the input strobe low while the operand changes, check that the last layer ignores that bit and that the register holds its value.

// File: rtl/perm_pkg.sv
package perm_pkg;
   // Number of conditional-move layers for a given data width.
   function automatic int layer_count(input int data_w);
      return $clog2(data_w);
   endfunction

   // Move distance of layer k (largest first).
   function automatic int layer_dist(input int data_w, input int k);
      return (data_w / 2) >> k;
   endfunction

   // Highest working-word position a layer may touch.
   function automatic int layer_last(input int data_w, input int k);
      return data_w - 2 + layer_dist(data_w, k);
   endfunction

   // Control bit tested by layer k.
   function automatic int layer_test_bit(input int data_w, input int k);
      return $clog2(layer_dist(data_w, k));
   endfunction

   // Index bit picking primary vs alternate amount; -1 means primary always.
   function automatic int layer_sel_bit(input int data_w, input int k);
      return layer_test_bit(data_w, k) - 1;
   endfunction

   localparam int STRIPE_IDX_BIT = 2;
endpackage

// File: rtl/perm_layer.sv
module perm_layer #(
   parameter int WORD_W     = 64,
   parameter int DIST       = 16,
   parameter int LAST       = 46,
   parameter int SEL_BIT    = 3,
   parameter int STRIPE_BIT = 2
) (
   input  logic [WORD_W-1:0] word_in,
   input  logic              ctl_a,
   input  logic              ctl_b,
   input  logic              stripe_en,
   output logic [WORD_W-1:0] word_out
);
   if (LAST + DIST >= WORD_W) begin : g_bad_range
      $error("perm_layer: source position beyond working word");
   end

   for (genvar i = 0; i < WORD_W; i++) begin : g_bit
      if (i <= LAST) begin : g_mv
         logic ctl_pick;
         logic ctl_eff;
         if (SEL_BIT < 0) begin : g_fixed
            assign ctl_pick = ctl_a;
         end else if (((i >> SEL_BIT) & 1) == 1) begin : g_prim
            assign ctl_pick = ctl_a;
         end else begin : g_alt
            assign ctl_pick = ctl_b;
         end
         if (STRIPE_BIT >= 0 && ((i >> STRIPE_BIT) & 1) == 0) begin : g_inv
            assign ctl_eff = ctl_pick ^ stripe_en;
         end else begin : g_plain
            assign ctl_eff = ctl_pick;
         end
         assign word_out[i] = ctl_eff ? word_in[i+DIST] : word_in[i];
      end else begin : g_keep
         assign word_out[i] = word_in[i];
      end
   end
endmodule

// File: rtl/perm_core.sv
module perm_core
   import perm_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int AMT_W  = $clog2(DATA_W),
   localparam int WORD_W = 2 * DATA_W,
   localparam int NLAYER = AMT_W
) (
   input  logic [DATA_W-1:0] operand,
   input  logic [AMT_W-1:0]  amt_a,
   input  logic [AMT_W-1:0]  amt_b,
   input  logic              stripe_en,
   output logic [DATA_W-1:0] permuted
);
   logic [WORD_W-1:0] chain [NLAYER+1];

   assign chain[0] = {operand, operand};

   for (genvar k = 0; k < NLAYER; k++) begin : g_layer
      localparam int TB = layer_test_bit(DATA_W, k);
      perm_layer #(
         .WORD_W    (WORD_W),
         .DIST      (layer_dist(DATA_W, k)),
         .LAST      (layer_last(DATA_W, k)),
         .SEL_BIT   (layer_sel_bit(DATA_W, k)),
         .STRIPE_BIT(k == 0 ? STRIPE_IDX_BIT : -1)
      ) u_layer (
         .word_in  (chain[k]),
         .ctl_a    (amt_a[TB]),
         .ctl_b    (amt_b[TB]),
         .stripe_en(stripe_en),
         .word_out (chain[k+1])
      );
   end

   logic [DATA_W-1:0] upper_unused;
   assign {upper_unused, permuted} = chain[NLAYER];
endmodule

// File: rtl/perm_out_stage.sv
module perm_out_stage #(
   parameter int DATA_W       = 32,
   parameter bit REGISTER_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] data_in,
   output logic              out_valid,
   output logic [DATA_W-1:0] data_out
);
   if (REGISTER_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            data_out  <= '0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) data_out <= data_in;
         end
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign out_valid  = in_valid;
      assign data_out   = data_in;
   end
endmodule

// File: rtl/bit_stripe_permuter.sv
module bit_stripe_permuter #(
   parameter int DATA_W       = 32,
   parameter bit REGISTER_OUT = 1'b1,
   localparam int AMT_W       = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] operand,
   input  logic [AMT_W-1:0]  amt_a,
   input  logic [AMT_W-1:0]  amt_b,
   input  logic              stripe_en,
   output logic              out_valid,
   output logic [DATA_W-1:0] result
);
   if (DATA_W != 32) begin : g_bad_width
      $error("bit_stripe_permuter: stripe pattern defined for 32-bit data only");
   end

   logic [DATA_W-1:0] permuted;

   perm_core #(.DATA_W(DATA_W)) u_core (
      .operand  (operand),
      .amt_a    (amt_a),
      .amt_b    (amt_b),
      .stripe_en(stripe_en),
      .permuted (permuted)
   );

   perm_out_stage #(.DATA_W(DATA_W), .REGISTER_OUT(REGISTER_OUT)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .data_in  (permuted),
      .out_valid(out_valid),
      .data_out (result)
   );
endmodule

// File: rtl/perm_checker.sv
module perm_checker #(
   parameter int DATA_W       = 32,
   parameter bit REGISTER_OUT = 1'b1,
   localparam int AMT_W       = $clog2(DATA_W)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [DATA_W-1:0] operand,
   input logic [AMT_W-1:0]  amt_a,
   input logic [AMT_W-1:0]  amt_b,
   input logic              stripe_en,
   input logic              out_valid,
   input logic [DATA_W-1:0] result
);
   function automatic logic [DATA_W-1:0] rotr(input logic [DATA_W-1:0] x,
                                              input logic [AMT_W-1:0] k);
      logic [2*DATA_W-1:0] w;
      w = {x, x} >> k;
      return w[DATA_W-1:0];
   endfunction

   function automatic logic [DATA_W-1:0] stripe_zero(input logic [DATA_W-1:0] x);
      return (rotr(x, AMT_W'(DATA_W/2)) & 32'h0F0F0F0F) | (x & 32'hF0F0F0F0);
   endfunction

   if (REGISTER_OUT) begin : g_reg_chk
      always @(negedge clk) begin
         if (!rst_n) begin
            assert_reset_clear_R1: assert (!out_valid && result == '0)
               else $error("R1: outputs not cleared in reset");
         end
      end

      assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
      assert_equal_rotate_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && amt_a == amt_b && !stripe_en)
         |=> result == rotr($past(operand), $past(amt_a)));
      assert_stripe_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && amt_a == '0 && amt_b == '0 && stripe_en)
         |=> result == stripe_zero($past(operand)));
      assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> $stable(result));
   end else begin : g_comb_chk
      assert_valid_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid == in_valid);
      assert_equal_rotate_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (amt_a == amt_b && !stripe_en) |-> result == rotr(operand, amt_a));
      assert_stripe_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (amt_a == '0 && amt_b == '0 && stripe_en) |-> result == stripe_zero(operand));
      assert_result_known_R5: assert property (@(posedge clk) disable iff (!rst_n)
         !$isunknown(operand) |-> !$isunknown(result));
   end
endmodule

bind bit_stripe_permuter perm_checker #(.DATA_W(DATA_W), .REGISTER_OUT(REGISTER_OUT)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .operand  (operand),
   .amt_a    (amt_a),
   .amt_b    (amt_b),
   .stripe_en(stripe_en),
   .out_valid(out_valid),
   .result   (result)
);

// File: tb/tb_bit_stripe_permuter.sv
module tb_bit_stripe_permuter;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG_CYCLES = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] operand = '0;
   logic [4:0]  amt_a = '0;
   logic [4:0]  amt_b = '0;
   logic        stripe_en = 1'b0;
   logic        out_valid;
   logic [31:0] result;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bit_stripe_permuter #(.DATA_W(32), .REGISTER_OUT(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
      .amt_a(amt_a), .amt_b(amt_b), .stripe_en(stripe_en),
      .out_valid(out_valid), .result(result)
   );

   // Reference model written from the layer definition.
   function automatic logic [31:0] ref_perm(input logic [31:0] x, input logic [4:0] a,
                                            input logic [4:0] b, input logic st);
      logic [63:0] cur, nxt;
      cur = {x, x};
      for (int k = 0; k < 5; k++) begin
         int d = 16 >> k;
         int tb = 4 - k;
         nxt = cur;
         for (int i = 0; i <= 30 + d; i++) begin
            logic [4:0] c;
            if (k == 4) c = a;
            else c = ((i >> (tb - 1)) & 1) != 0 ? a : b;
            if (k == 0 && st && ((i >> 2) & 1) == 0) c = ~c;
            if (c[tb]) nxt[i] = cur[i + d];
         end
         cur = nxt;
      end
      return cur[31:0];
   endfunction

   function automatic logic [31:0] rot_right(input logic [31:0] x, input int k);
      logic [63:0] w;
      w = {x, x} >> k;
      return w[31:0];
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Present one vector for one cycle; result checked at following negedge.
   task automatic apply(input logic [31:0] x, input logic [4:0] a, input logic [4:0] b,
                        input logic st);
      operand = x; amt_a = a; amt_b = b; stripe_en = st; in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic t_reset_R1();
      @(negedge clk);
      check("R1 out_valid", {31'd0, out_valid}, 32'd0);
      check("R1 result", result, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_latency_R2();
      apply(32'hDEADBEEF, 5'd3, 5'd3, 1'b0);
      check("R2 valid high", {31'd0, out_valid}, 32'd1);
      check("R2 data", result, ref_perm(32'hDEADBEEF, 5'd3, 5'd3, 1'b0));
      @(negedge clk);
      check("R2 valid low", {31'd0, out_valid}, 32'd0);
   endtask

   task automatic t_rotate_R3();
      for (int k = 0; k < 32; k++) begin
         apply(32'h8421_C3A5, 5'(k), 5'(k), 1'b0);
         check("R3 rotate", result, rot_right(32'h8421_C3A5, k));
      end
      apply(32'h1357_9BDF, 5'd0, 5'd0, 1'b0);
      check("R3 identity", result, 32'h1357_9BDF);
   endtask

   task automatic t_stripe_zero_R4();
      logic [31:0] pats [3] = '{32'h0000_FFFF, 32'hA5C3_0F96, 32'hFFFF_0000};
      for (int p = 0; p < 3; p++) begin
         apply(pats[p], 5'd0, 5'd0, 1'b1);
         check("R4 stripe", result,
               (rot_right(pats[p], 16) & 32'h0F0F0F0F) | (pats[p] & 32'hF0F0F0F0));
      end
   endtask

   task automatic t_sweep_R5();
      logic [31:0] ops [2] = '{32'h0123_4567, 32'hF00D_5A3C};
      for (int o = 0; o < 2; o++)
         for (int st = 0; st < 2; st++)
            for (int a = 0; a < 32; a++)
               for (int b = 0; b < 32; b++) begin
                  apply(ops[o], 5'(a), 5'(b), st[0]);
                  check("R5 sweep", result, ref_perm(ops[o], 5'(a), 5'(b), st[0]));
               end
   endtask

   task automatic t_hold_R6();
      logic [31:0] held;
      apply(32'hCAFE_1234, 5'd7, 5'd19, 1'b1);
      held = result;
      operand = 32'h5555_AAAA; amt_a = 5'd1; amt_b = 5'd30; stripe_en = 1'b0;
      @(negedge clk);
      check("R6 hold", result, held);
      @(negedge clk);
      check("R6 hold2", result, held);
   endtask

   task automatic t_alt_lsb_R7();
      logic [31:0] r0;
      for (int a = 0; a < 32; a += 5) begin
         apply(32'h9E37_79B9, 5'(a), 5'b10110, 1'b1);
         r0 = result;
         apply(32'h9E37_79B9, 5'(a), 5'b10111, 1'b1);
         check("R7 alt lsb", result, r0);
      end
   endtask

   initial begin
      repeat (WATCHDOG_CYCLES) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      t_reset_R1();
      t_latency_R2();
      t_rotate_R3();
      t_stripe_zero_R4();
      t_sweep_R5();
      t_hold_R6();
      t_alt_lsb_R7();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule